// File: doc/BRIEF.md
# Strobed Latch 4-to-16 Line Decoder

This block keeps a 4-bit binary code in a hold register and turns the held value into a one-of-sixteen selection on its output lines. A strobe input decides when a new code is taken. While strobe is high, the register copies the data inputs on every clock edge. Once strobe goes low, the register keeps the value it had just before the fall. A separate inhibit input blanks the whole output bus at once, whatever the code and the strobe are doing. Typical uses are address decoding, selecting one of sixteen channels, and decoding a program-counter or hex digit.

The output polarity is fixed at elaboration. In the active-high form, the selected line is 1 and the rest are 0. In the active-low form, the selected line is 0 and the rest are 1. Blanking drives every line to its inactive level: 0 for active-high, 1 for active-low. The hold register uses the system clock with a synchronous reset. Inhibit acts on the outputs without a clock and never reaches the register.

Top module: `strobed_decoder`

## Requirements
- R1: A synchronous reset clears the held code to 0, so after reset, with inhibit low, output line 0 is the only selected line.
- R2: While strobe is 1 at a clock edge, the held code takes the value on data, and the outputs show that code from the edge onward (one cycle of registration).
- R3: While strobe is 0 at a clock edge, the held code keeps the last value taken before strobe fell, and changes on data do not reach the outputs.
- R4: Output line i is selected exactly when the held code equals i, with data[0] as the least significant bit. With inhibit low, exactly one line is selected for each of the 16 codes.
- R5: With ACTIVE_HIGH=1 (the default), the selected line is 1 and every other line is 0.
- R6: While inhibit is 1, every output is at its inactive level (all 0 when ACTIVE_HIGH=1, all 1 when ACTIVE_HIGH=0), in the same cycle, whatever data and strobe are.
- R7: Inhibit does not alter the held code. The register keeps following strobe while inhibit is high, and when inhibit returns to 0 the outputs show the held code again.
- R8: With ACTIVE_HIGH=0, the selected line is 0 and every other line is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| data | input | 4 | Binary code to capture, bit 0 least significant |
| strobe | input | 1 | 1 = register follows data, 0 = register holds |
| inhibit | input | 1 | 1 = force all outputs inactive |
| out | output | 16 | One-hot decoded lines, polarity set by ACTIVE_HIGH |

## Verification
The bench changes data while strobe is low. A design that let the register stay open would move the selection to the new code instead of holding it. The bench raises inhibit between clock edges and checks the outputs before the next edge, which exposes blanking done through a register. It changes the code under inhibit and then releases it, which catches a design that clears or freezes the register while inhibited. Two instances with opposite polarity go through every one of the 16 codes, which exposes a swapped bit order or a wrong blanking level in either variant.

// File: rtl/stdec_pkg.sv
`timescale 1ns/1ps
package stdec_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;   // register copies data at this edge
    logic blank;  // force outputs to the inactive level
  } stdec_ctrl_t;
endpackage

// File: rtl/strobed_decoder_ctrl.sv
`timescale 1ns/1ps
module strobed_decoder_ctrl
  import stdec_pkg::*;
(
  input  logic        strobe,
  input  logic        inhibit,
  output stdec_ctrl_t ctrl
);
  // Inhibit never gates the load: the register keeps running underneath.
  always_comb begin
    ctrl.load  = strobe;
    ctrl.blank = inhibit;
  end
endmodule

// File: rtl/strobed_decoder_dp.sv
`timescale 1ns/1ps
module strobed_decoder_dp
  import stdec_pkg::*;
#(
  parameter int CODE_W      = 4,
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [CODE_W-1:0]      data,
  input  stdec_ctrl_t            ctrl,
  output logic [(1<<CODE_W)-1:0] out
);
  localparam int LINES = 1 << CODE_W;

  logic [CODE_W-1:0] heldCode;
  logic [LINES-1:0]  selLines;
  logic [LINES-1:0]  activePattern;
  logic [LINES-1:0]  idleLevel;

  always_ff @(posedge clk) begin
    if (rst)            heldCode <= '0;
    else if (ctrl.load) heldCode <= data;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign selLines[i] = (heldCode == CODE_W'(i));
  end

  if (ACTIVE_HIGH) begin : g_pol_high
    assign activePattern = selLines;
    assign idleLevel     = '0;
  end else begin : g_pol_low
    assign activePattern = ~selLines;
    assign idleLevel     = '1;
  end

  always_comb out = ctrl.blank ? idleLevel : activePattern;
endmodule

// File: rtl/strobed_decoder.sv
`timescale 1ns/1ps
module strobed_decoder
  import stdec_pkg::*;
#(
  parameter int CODE_W      = 4,
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [CODE_W-1:0]      data,
  input  logic                   strobe,
  input  logic                   inhibit,
  output logic [(1<<CODE_W)-1:0] out
);
  stdec_ctrl_t ctrl;

  strobed_decoder_ctrl u_ctrl (
    .strobe (strobe),
    .inhibit(inhibit),
    .ctrl   (ctrl)
  );

  strobed_decoder_dp #(.CODE_W(CODE_W), .ACTIVE_HIGH(ACTIVE_HIGH)) u_dp (
    .clk (clk),
    .rst (rst),
    .data(data),
    .ctrl(ctrl),
    .out (out)
  );
endmodule

// File: rtl/strobed_decoder_chk.sv
`timescale 1ns/1ps
module strobed_decoder_chk #(
  parameter int CODE_W      = 4,
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input logic                   clk,
  input logic                   rst,
  input logic [CODE_W-1:0]      data,
  input logic                   strobe,
  input logic                   inhibit,
  input logic [(1<<CODE_W)-1:0] out
);
  localparam int LINES = 1 << CODE_W;
  localparam logic [LINES-1:0] IDLE = ACTIVE_HIGH ? '0 : '1;

  function automatic logic [LINES-1:0] pattern(input logic [CODE_W-1:0] code);
    logic [LINES-1:0] v;
    v = '0;
    v[code] = 1'b1;
    return ACTIVE_HIGH ? v : ~v;
  endfunction

  logic seen = 1'b0;
  always_ff @(posedge clk) seen <= 1'b1;

  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(rst) && !inhibit) |-> out == pattern('0));

  p_follow_r2: assert property (@(posedge clk) disable iff (rst)
    (seen && !$past(rst) && $past(strobe) && !inhibit) |-> out == pattern($past(data)));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (seen && !$past(rst) && !$past(strobe) && !$past(inhibit) && !inhibit) |-> $stable(out));

  p_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    !inhibit |-> $countones(ACTIVE_HIGH ? out : ~out) == 1);

  p_blank_r6: assert property (@(posedge clk) disable iff (rst)
    inhibit |-> out == IDLE);
endmodule

bind strobed_decoder strobed_decoder_chk #(.CODE_W(CODE_W), .ACTIVE_HIGH(ACTIVE_HIGH)) u_chk (
  .clk(clk), .rst(rst), .data(data), .strobe(strobe), .inhibit(inhibit), .out(out)
);

// File: tb/strobed_decoder_tb.sv
`timescale 1ns/1ps
module strobed_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  data = '0;
  logic        strobe = 1'b0;
  logic        inhibit = 1'b0;
  logic [15:0] outHi, outLo;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  strobed_decoder #(.ACTIVE_HIGH(1'b1)) u_dut (
    .clk(clk), .rst(rst), .data(data), .strobe(strobe), .inhibit(inhibit), .out(outHi));
  strobed_decoder #(.ACTIVE_HIGH(1'b0)) u_dut_lo (
    .clk(clk), .rst(rst), .data(data), .strobe(strobe), .inhibit(inhibit), .out(outLo));

  // vector: [10:7] data, [6] strobe, [5] inhibit, [4:1] expected code, [0] expected blank
  localparam int NVEC = 11;
  localparam logic [10:0] VEC [NVEC] = '{
    {4'd5,  1'b1, 1'b0, 4'd5,  1'b0},  // R2
    {4'd9,  1'b1, 1'b0, 4'd9,  1'b0},  // R2
    {4'd3,  1'b0, 1'b0, 4'd9,  1'b0},  // R3 hold
    {4'd15, 1'b0, 1'b0, 4'd9,  1'b0},  // R3 hold
    {4'd15, 1'b1, 1'b0, 4'd15, 1'b0},  // R2
    {4'd0,  1'b1, 1'b1, 4'd0,  1'b1},  // R6 blank, register loads 0
    {4'd7,  1'b0, 1'b1, 4'd0,  1'b1},  // R6
    {4'd7,  1'b0, 1'b0, 4'd0,  1'b0},  // R7 held 0 reappears
    {4'd12, 1'b1, 1'b0, 4'd12, 1'b0},  // R2
    {4'd1,  1'b0, 1'b1, 4'd12, 1'b1},  // R6
    {4'd1,  1'b0, 1'b0, 4'd12, 1'b0}   // R7
  };

  function automatic logic [15:0] expHi(input logic [3:0] code, input logic blank);
    logic [15:0] v;
    v = '0;
    if (!blank) v[code] = 1'b1;
    return v;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkBoth(input string reqHi, input string reqLo,
                           input logic [3:0] code, input logic blank);
    check(reqHi, outHi, expHi(code, blank));
    check(reqLo, outLo, ~expHi(code, blank));
  endtask

  task automatic drive(input logic [3:0] d, input logic s, input logic inh);
    @(negedge clk);
    data = d; strobe = s; inhibit = inh;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    // R1: reset state
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1 checkBoth("R1 reset hi", "R1 reset lo", 4'd0, 1'b0);

    // table walk
    for (int k = 0; k < NVEC; k++) begin
      string tag;
      drive(VEC[k][10:7], VEC[k][6], VEC[k][5]);
      @(posedge clk); #1;
      tag = VEC[k][0] ? "R6" : (!VEC[k][6] ? (k == 7 || k == 10 ? "R7" : "R3") : "R2");
      checkBoth({tag, " R5 hi"}, {tag, " R8 lo"}, VEC[k][4:1], VEC[k][0]);
    end

    // R4: every code, bit order data[0] = LSB
    for (int c = 0; c < 16; c++) begin
      drive(4'(c), 1'b1, 1'b0);
      @(posedge clk); #1;
      checkBoth("R4 R5 code hi", "R4 R8 code lo", 4'(c), 1'b0);
    end

    // R6: inhibit acts within the cycle, before any edge
    drive(4'd6, 1'b1, 1'b0);
    @(posedge clk); #1;
    checkBoth("R2 hi", "R2 lo", 4'd6, 1'b0);
    @(negedge clk);
    data = 4'd11; inhibit = 1'b1;
    #1 checkBoth("R6 same-cycle hi", "R6 same-cycle lo", 4'd0, 1'b1);
    @(posedge clk); #1;
    // R7: register followed strobe under inhibit; released shows 11
    drive(4'd2, 1'b0, 1'b0);
    #1 checkBoth("R7 release hi", "R7 release lo", 4'd11, 1'b0);

    // R1: reset mid-operation clears a non-zero held code
    drive(4'd9, 1'b1, 1'b0);
    @(posedge clk);
    @(negedge clk); rst = 1'b1; strobe = 1'b0;
    @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1 checkBoth("R1 mid reset hi", "R1 mid reset lo", 4'd0, 1'b0);

    // R3: data toggling with strobe low changes nothing across edges
    for (int j = 0; j < 4; j++) begin
      drive(4'(j * 5 + 1), 1'b0, 1'b0);
      @(posedge clk); #1;
      checkBoth("R3 hold hi", "R3 hold lo", 4'd0, 1'b0);
    end

    repeat (2) @(posedge clk);
    finish();
  end
endmodule